// File: doc/BRIEF.md
# Shared Interrupt Source Router

This block keeps the per-source state for a bank of external interrupt lines and steers every active source to one interrupt line of one processor. Each source carries an enable flag, a pending flag, a pin selection with a route flag, and a target processor. Software configures the sources through a 32-bit register port. Enables are changed with separate write-one-to-set and write-one-to-clear words. The target processor is written as a one-hot word and kept as an index. A trigger register lets software force any source's pending state.

Each processor owns eight interrupt lines. A source on pin `p` drives line `p + 2` of its processor, so lines 0 and 1 are never driven. Every line is the registered OR of all sources that are enabled, pending, routed and mapped to that processor and pin. Polarity and edge settings, vectored delivery and non-maskable delivery are not part of this block.

Register map (byte addresses, one 32-bit word each). `w` is a word index and bit `b` of word `w` belongs to source `32*w + b`. `s` is a source number.
- `0x000 + 4w`: set-enable (write only, reads 0)
- `0x100 + 4w`: clear-enable (write only, reads 0)
- `0x200 + 4w`: enable status (read only)
- `0x300 + 4w`: pending status (read only)
- `0x400`: software trigger
- `0x800 + 4s`: pin map
- `0xC00 + 4s`: target map

Top module: `irqRouter`

## Requirements
- R1: After reset, every enable bit and pending bit is 0. Every pin map reads 0x8000_0000, meaning the route flag is set and the pin is 0. Every target map reads 0, and all output lines are low.
- R2: Writing a 1 to bit b of set-enable word w enables source 32w+b, and writing a 1 to that bit of clear-enable word w disables it. Bits written as 0 leave their enables unchanged. The enable status word returns the enable bits.
- R3: A word index that addresses only sources at or beyond NUM_SRC reads 0 in the status regions, and writes to it have no effect. Status bits for sources at or beyond NUM_SRC read 0.
- R4: Pin map bit 31 is the route flag and bits 5:0 are the pin number; bits 30:6 read 0. A write whose bits 5:0 exceed 5 leaves the register unchanged.
- R5: A nonzero write to a target map stores the index of the lowest set bit, and reads return 1 shifted left by that index. A write of 0 marks the source unmapped, and reads then return 0. A write whose lowest set bit is at or above NUM_CPU leaves the register unchanged.
- R6: A write to the trigger register sets the pending bit of the source numbered in bits 30:0 to the value of bit 31. A source number at or beyond NUM_SRC is ignored.
- R7: When a source input changes level, that source's pending bit takes the new level on the same clock edge.
- R8: Output line `8*c + p + 2` is high exactly when some source is enabled, pending, has its route flag set, targets processor c and selects pin p. Lines `8*c` and `8*c + 1` are always low.
- R9: A line shared by several sources stays high while any of them still qualifies. It falls only after the last one stops qualifying.
- R10: Output lines follow a state change after exactly one further clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Level of each external interrupt source |
| busAddr | input | 12 | Register byte address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| irqLines | output | NUM_CPU*8 | Eight interrupt lines per processor, registered |

## Verification
Corrupted enable, pending, pin or target state shows up at the ports in two ways. The status and map words read back the wrong value immediately after the write edge. The affected processor line is wrong one clock later. A routing fault, such as a wrong processor index, a missing pin offset or a lost OR term, sends a line to the wrong bit position or drops a shared line early. The sweeps drive every source through every target and pin class and compare the whole line vector at the exact edge where it must change.

// File: rtl/irqRouterPkg.sv
package irqRouterPkg;
  localparam int LINES_PER_CPU = 8;
  localparam int LINE_OFFSET   = 2;
  localparam int PIN_MAX       = 5;

  typedef enum logic [2:0] {RD_NONE, RD_EN, RD_PEND, RD_PIN, RD_TGT} rdKind_t;

  typedef struct packed {
    logic       setEn;
    logic       clrEn;
    logic       trig;
    logic       trigVal;
    logic [7:0] trigIdx;
    logic       pinWr;
    logic       tgtWr;
    logic       tgtSet;
    logic [4:0] tgtIdx;
    rdKind_t    rdKind;
    logic [7:0] idx;
  } strobe_t;
endpackage

// File: rtl/irqRouterCtrl.sv
module irqRouterCtrl
  import irqRouterPkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  parameter int WORDS   = 2
) (
  input  logic [11:0] busAddr,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output strobe_t     stb
);
  localparam logic [6:0]  WORDS_L = 7'(WORDS);
  localparam logic [8:0]  SRC_L   = 9'(NUM_SRC);
  localparam logic [30:0] SRC_T   = 31'(NUM_SRC);
  localparam logic [5:0]  CPU_L   = 6'(NUM_CPU);

  logic [1:0] region;
  logic [1:0] subRegion;
  logic [5:0] wordIdx;
  logic [7:0] srcIdx;
  logic       wordOk;
  logic       srcOk;
  logic [4:0] lowIdx;
  logic       anySet;

  assign region    = busAddr[11:10];
  assign subRegion = busAddr[9:8];
  assign wordIdx   = busAddr[7:2];
  assign srcIdx    = busAddr[9:2];
  assign wordOk    = {1'b0, wordIdx} < WORDS_L;
  assign srcOk     = {1'b0, srcIdx} < SRC_L;

  always_comb begin
    lowIdx = '0;
    anySet = 1'b0;
    for (int b = 31; b >= 0; b--) begin
      if (busWrData[b]) begin
        lowIdx = 5'(b);
        anySet = 1'b1;
      end
    end
  end

  always_comb begin
    stb        = '0;
    stb.rdKind = RD_NONE;
    unique case (region)
      2'b00: begin
        stb.idx = {2'b00, wordIdx};
        if (wordOk) begin
          unique case (subRegion)
            2'd0: stb.setEn = busWrEn;
            2'd1: stb.clrEn = busWrEn;
            2'd2: stb.rdKind = RD_EN;
            default: stb.rdKind = RD_PEND;
          endcase
        end
      end
      2'b01: begin
        if (srcIdx == 8'd0 && busWrEn && busWrData[30:0] < SRC_T) begin
          stb.trig    = 1'b1;
          stb.trigVal = busWrData[31];
          stb.trigIdx = busWrData[7:0];
        end
      end
      2'b10: begin
        stb.idx = srcIdx;
        if (srcOk) begin
          stb.rdKind = RD_PIN;
          stb.pinWr  = busWrEn && (busWrData[5:0] <= 6'(PIN_MAX));
        end
      end
      default: begin
        stb.idx = srcIdx;
        if (srcOk) begin
          stb.rdKind = RD_TGT;
          stb.tgtSet = anySet;
          stb.tgtIdx = lowIdx;
          stb.tgtWr  = busWrEn && (!anySet || ({1'b0, lowIdx} < CPU_L));
        end
      end
    endcase
  end
endmodule

// File: rtl/irqRouterDp.sv
module irqRouterDp
  import irqRouterPkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4,
  parameter int WORDS   = 2
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_SRC-1:0]              srcIn,
  input  strobe_t                         stb,
  input  logic [31:0]                     busWrData,
  output logic [31:0]                     busRdData,
  output logic [NUM_CPU*LINES_PER_CPU-1:0] irqLines
);
  localparam int NUM_LINES = NUM_CPU * LINES_PER_CPU;

  logic [NUM_SRC-1:0] enable;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] routeBit;
  logic [NUM_SRC-1:0] tgtValid;
  logic [5:0]         pinNum [NUM_SRC];
  logic [4:0]         tgtIdx [NUM_SRC];
  logic [NUM_SRC-1:0] active;
  logic [NUM_LINES-1:0] irqNext;
  logic [WORDS*32-1:0]  enPad;
  logic [WORDS*32-1:0]  pendPad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= '0;
      pending  <= '0;
      srcPrev  <= '0;
      routeBit <= '1;
      tgtValid <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        pinNum[i] <= '0;
        tgtIdx[i] <= '0;
      end
    end else begin
      srcPrev <= srcIn;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.setEn && stb.idx == 8'(i / 32) && busWrData[i % 32])
          enable[i] <= 1'b1;
        else if (stb.clrEn && stb.idx == 8'(i / 32) && busWrData[i % 32])
          enable[i] <= 1'b0;
        if (stb.trig && stb.trigIdx == 8'(i))
          pending[i] <= stb.trigVal;
        else if (srcIn[i] != srcPrev[i])
          pending[i] <= srcIn[i];
        if (stb.pinWr && stb.idx == 8'(i)) begin
          routeBit[i] <= busWrData[31];
          pinNum[i]   <= busWrData[5:0];
        end
        if (stb.tgtWr && stb.idx == 8'(i)) begin
          tgtValid[i] <= stb.tgtSet;
          tgtIdx[i]   <= stb.tgtIdx;
        end
      end
    end
  end

  assign active = enable & pending & routeBit & tgtValid;

  for (genvar gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
    for (genvar gl = 0; gl < LINES_PER_CPU; gl++) begin : g_line
      if (gl < LINE_OFFSET) begin : g_unused
        assign irqNext[gc*LINES_PER_CPU+gl] = 1'b0;
      end else begin : g_used
        always_comb begin
          irqNext[gc*LINES_PER_CPU+gl] = 1'b0;
          for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && tgtIdx[i] == 5'(gc) && pinNum[i] == 6'(gl - LINE_OFFSET))
              irqNext[gc*LINES_PER_CPU+gl] = 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqLines <= '0;
    else       irqLines <= irqNext;
  end

  always_comb begin
    enPad   = '0;
    pendPad = '0;
    enPad[NUM_SRC-1:0]   = enable;
    pendPad[NUM_SRC-1:0] = pending;
    busRdData = '0;
    unique case (stb.rdKind)
      RD_EN: begin
        for (int w = 0; w < WORDS; w++)
          if (stb.idx == 8'(w)) busRdData = enPad[w*32 +: 32];
      end
      RD_PEND: begin
        for (int w = 0; w < WORDS; w++)
          if (stb.idx == 8'(w)) busRdData = pendPad[w*32 +: 32];
      end
      RD_PIN: begin
        for (int i = 0; i < NUM_SRC; i++)
          if (stb.idx == 8'(i)) busRdData = {routeBit[i], 25'd0, pinNum[i]};
      end
      RD_TGT: begin
        for (int i = 0; i < NUM_SRC; i++)
          if (stb.idx == 8'(i) && tgtValid[i]) busRdData = 32'd1 << tgtIdx[i];
      end
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/irqRouter.sv
module irqRouter
  import irqRouterPkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_SRC-1:0]     srcIn,
  input  logic [11:0]            busAddr,
  input  logic                   busWrEn,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  output logic [NUM_CPU*8-1:0]   irqLines
);
  localparam int WORDS = (NUM_SRC + 31) / 32;

  strobe_t stb;

  irqRouterCtrl #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .WORDS(WORDS)) uCtrl (
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .stb      (stb)
  );

  irqRouterDp #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .WORDS(WORDS)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIn    (srcIn),
    .stb      (stb),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irqLines (irqLines)
  );
endmodule

// File: rtl/irqRouterChk.sv
module irqRouterChk #(
  parameter int NUM_SRC = 40,
  parameter int NUM_CPU = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SRC-1:0]   srcIn,
  input logic [11:0]          busAddr,
  input logic                 busWrEn,
  input logic [31:0]          busWrData,
  input logic [31:0]          busRdData,
  input logic [NUM_CPU*8-1:0] irqLines
);
  localparam logic [6:0] WORDS_L = 7'((NUM_SRC + 31) / 32);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_low
    // R8
    low_line_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqLines[c*8 +: 2] == 2'b00);
  end

  // R3
  beyond_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[11:10] == 2'b00 && busAddr[9] && {1'b0, busAddr[7:2]} >= WORDS_L)
      |-> busRdData == 32'd0);

  // R4
  pin_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[11:10] == 2'b10) |-> busRdData[30:6] == 25'd0);

  // R5
  tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[11:10] == 2'b11) |-> $onehot0(busRdData));

  // R10
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && $stable(srcIn) && $past(rstN)) |=> ##1 $stable(irqLines));
endmodule

bind irqRouter irqRouterChk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .srcIn    (srcIn),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irqLines (irqLines)
);

// File: tb/irqRouter_test.sv
`timescale 1ns/1ps
module irqRouter_test;
  localparam int NS = 40;
  localparam int NC = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NS-1:0]     srcIn = '0;
  logic [11:0]       busAddr = '0;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic [NC*8-1:0]   irqLines;

  int checks = 0;
  int failures = 0;
  logic [31:0] rdv;

  bit mEn [NS];
  bit mPend [NS];
  bit mRoute [NS];
  int mPin [NS];
  int mTgt [NS];

  irqRouter #(.NUM_SRC(NS), .NUM_CPU(NC)) uut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .irqLines(irqLines)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] word(input int kind, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) begin
      if (32*w + b < NS) r[b] = (kind == 0) ? mEn[32*w+b] : mPend[32*w+b];
    end
    return r;
  endfunction

  function automatic logic [NC*8-1:0] expIrq();
    logic [NC*8-1:0] r = '0;
    for (int s = 0; s < NS; s++)
      if (mEn[s] && mPend[s] && mRoute[s] && mTgt[s] >= 0)
        r[mTgt[s]*8 + mPin[s] + 2] = 1'b1;
    return r;
  endfunction

  task automatic setEnW(input int w, input logic [31:0] d);
    wr(12'(w*4), d);
    for (int b = 0; b < 32; b++) if (d[b] && 32*w+b < NS) mEn[32*w+b] = 1;
  endtask

  task automatic clrEnW(input int w, input logic [31:0] d);
    wr(12'(12'h100 + w*4), d);
    for (int b = 0; b < 32; b++) if (d[b] && 32*w+b < NS) mEn[32*w+b] = 0;
  endtask

  task automatic trig(input int s, input bit v);
    wr(12'h400, {v, 31'(s)});
    if (s < NS) mPend[s] = v;
  endtask

  task automatic setPin(input int s, input bit route, input int p);
    wr(12'(12'h800 + s*4), {route, 25'h1FF_FFFF, 6'(p)});
    if (p <= 5) begin mRoute[s] = route; mPin[s] = p; end
  endtask

  task automatic setTgt(input int s, input logic [31:0] d);
    int low = -1;
    wr(12'(12'hC00 + s*4), d);
    for (int b = 31; b >= 0; b--) if (d[b]) low = b;
    if (low < NC) mTgt[s] = low;
  endtask

  function automatic logic [31:0] pinExp(input int s);
    return {mRoute[s], 25'd0, 6'(mPin[s])};
  endfunction

  function automatic logic [31:0] tgtExp(input int s);
    return (mTgt[s] < 0) ? 32'd0 : (32'd1 << mTgt[s]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      mEn[s] = 0; mPend[s] = 0; mRoute[s] = 1; mPin[s] = 0; mTgt[s] = -1;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int w = 0; w < 2; w++) begin
      rd(12'(12'h200 + w*4), rdv); chk("R1 enable", rdv, 0);
      rd(12'(12'h300 + w*4), rdv); chk("R1 pending", rdv, 0);
    end
    for (int s = 0; s < NS; s++) begin
      rd(12'(12'h800 + s*4), rdv); chk("R1 pin map", rdv, 32'h8000_0000);
      rd(12'(12'hC00 + s*4), rdv); chk("R1 target", rdv, 0);
    end
    chk("R1 lines", 32'(irqLines), 0);

    // R2 set/clear enable
    setEnW(0, 32'hA5A5_0F0F);
    rd(12'h200, rdv); chk("R2 set", rdv, word(0, 0));
    setEnW(0, 32'h0);
    rd(12'h200, rdv); chk("R2 zero write", rdv, word(0, 0));
    clrEnW(0, 32'h8001_0F00);
    rd(12'h200, rdv); chk("R2 clear", rdv, word(0, 0));
    clrEnW(0, 32'h0);
    rd(12'h200, rdv); chk("R2 zero clear", rdv, word(0, 0));
    // R3 bits beyond source count
    setEnW(1, 32'hFFFF_FFFF);
    rd(12'h204, rdv); chk("R3 partial word", rdv, 32'h0000_00FF);
    clrEnW(1, 32'h0000_000F);
    rd(12'h204, rdv); chk("R2 clear word1", rdv, 32'h0000_00F0);
    // R3 words past the end
    for (int w = 2; w < 8; w++) begin
      wr(12'(w*4), 32'hFFFF_FFFF);
      rd(12'(12'h200 + w*4), rdv); chk("R3 en beyond", rdv, 0);
      rd(12'(12'h300 + w*4), rdv); chk("R3 pend beyond", rdv, 0);
    end
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h200, rdv); chk("R3 no effect w0", rdv, word(0, 0));
    rd(12'h204, rdv); chk("R3 no effect w1", rdv, word(0, 1));
    clrEnW(0, 32'hFFFF_FFFF);
    clrEnW(1, 32'hFFFF_FFFF);

    // R4 pin map
    for (int s = 0; s < NS; s++) begin
      setPin(s, s[0], s % 6);
      rd(12'(12'h800 + s*4), rdv); chk("R4 pin write", rdv, pinExp(s));
    end
    for (int p = 6; p < 64; p++) begin
      setPin(3, 1'b0, p);
      rd(12'h80C, rdv); chk("R4 pin reject", rdv, pinExp(3));
    end

    // R5 target map
    for (int s = 0; s < NS; s++) begin
      for (int c = 0; c < NC; c++) begin
        setTgt(s, (32'd1 << c) | (32'd1 << (c + 3)));
        rd(12'(12'hC00 + s*4), rdv); chk("R5 target", rdv, tgtExp(s));
      end
    end
    setTgt(7, 32'h0000_0010);
    rd(12'hC1C, rdv); chk("R5 reject high cpu", rdv, tgtExp(7));
    setTgt(7, 32'hFFFF_FFF0);
    rd(12'hC1C, rdv); chk("R5 reject low bit high", rdv, tgtExp(7));
    setTgt(7, 32'h0);
    rd(12'hC1C, rdv); chk("R5 unmapped", rdv, 0);

    // R6 trigger
    for (int s = 0; s < NS; s += 3) trig(s, 1'b1);
    rd(12'h300, rdv); chk("R6 trigger w0", rdv, word(1, 0));
    rd(12'h304, rdv); chk("R6 trigger w1", rdv, word(1, 1));
    trig(NS, 1'b1);
    trig(NS + 1000, 1'b1);
    trig(32'h7FFF_FFFF, 1'b0);
    rd(12'h304, rdv); chk("R6 out of range", rdv, word(1, 1));
    for (int s = 0; s < NS; s += 3) trig(s, 1'b0);
    rd(12'h300, rdv); chk("R6 clear", rdv, 0);

    // R7 input level changes
    @(negedge clk); srcIn = 40'h80_0000_1234;
    for (int s = 0; s < NS; s++) mPend[s] = srcIn[s];
    @(negedge clk);
    rd(12'h300, rdv); chk("R7 rise w0", rdv, word(1, 0));
    rd(12'h304, rdv); chk("R7 rise w1", rdv, word(1, 1));
    trig(4, 1'b0);
    rd(12'h300, rdv); chk("R7 held level no retrigger", rdv, word(1, 0));
    @(negedge clk); srcIn = '0;
    for (int s = 0; s < NS; s++) mPend[s] = 0;
    @(negedge clk);
    rd(12'h300, rdv); chk("R7 fall", rdv, 0);
    rd(12'h304, rdv); chk("R7 fall w1", rdv, 0);

    // R8 routing sweep, one source at a time; R10 timing
    for (int s = 0; s < NS; s++) begin
      setPin(s, 1'b1, s % 6);
      setTgt(s, 32'd1 << (s % NC));
      setEnW(s / 32, 32'd1 << (s % 32));
      trig(s, 1'b1);
      chk("R10 not yet", 32'(irqLines), 0);
      @(negedge clk);
      chk("R8 routed line", 32'(irqLines), 32'(expIrq()));
      trig(s, 1'b0);
      @(negedge clk);
      chk("R8 line drops", 32'(irqLines), 0);
      clrEnW(s / 32, 32'd1 << (s % 32));
    end

    // R8 route flag blocks delivery
    setPin(5, 1'b0, 2);
    setEnW(0, 32'h20);
    trig(5, 1'b1);
    @(negedge clk);
    chk("R8 route flag clear", 32'(irqLines), 0);
    trig(5, 1'b0);
    clrEnW(0, 32'h20);

    // R9 shared line OR
    setPin(1, 1'b1, 3); setTgt(1, 32'h4);
    setPin(33, 1'b1, 3); setTgt(33, 32'h4);
    setEnW(0, 32'h2); setEnW(1, 32'h2);
    trig(1, 1'b1); trig(33, 1'b1);
    @(negedge clk);
    chk("R9 both", 32'(irqLines), 32'(expIrq()));
    trig(1, 1'b0);
    @(negedge clk);
    chk("R9 one left", 32'(irqLines), 32'd1 << (2*8 + 5));
    clrEnW(1, 32'h2);
    @(negedge clk);
    chk("R9 last gone", 32'(irqLines), 0);
    setEnW(1, 32'h2);
    @(negedge clk);
    chk("R9 reenabled", 32'(irqLines), 32'(expIrq()));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule